// File: doc/BRIEF.md
# Memory Traffic Pattern Generator and Read-Back Checker

This block supplies the write data for a memory traffic test and judges the data that comes back. A test driver issues words one at a time. It places a word address on the address input and pulses the write strobe to take the word shown on the generator output. Later it returns stored words on the read-data input together with a read strobe. The checker regenerates the word expected at that read position and compares the two. Any difference latches a status flag that stays set until reset, so it can drive an indicator lamp.

Six data patterns can be selected with a 3-bit mode input, and the mode is captured only while reset is held. The patterns are the address used as data, full-bus toggling (hammer), a single odd bit on a background that flips every word (neighbor), a walking one, a walking zero, and a 16-bit pseudo-random sequence. The write side and the read side each keep their own word counter and their own pseudo-random register, and each advances only on its own strobe. Expected data therefore comes from the read position and no copy of the written data is stored.

The error flag is held in a two-state machine. The states are CHK_CLEAN, which is the reset state, and CHK_FAILED. The only transition is CLEAN_TO_FAILED, taken when a read strobe carries a mismatching word. The machine then holds FAILED until reset.

Top module: `memtest_pattern_unit`

## Requirements
- R1: The pattern is chosen from the mode input as it stands at the last clock edge with reset low. The encodings are 3'b010 address, 3'b011 hammer, 3'b100 neighbor, 3'b101 walking one, 3'b110 walking zero and 3'b111 PRBS. Changing the mode input while out of reset has no effect on the output words.
- R2: In hammer mode, word k is 16'hFFFF for even k and 16'h0000 for odd k. Modes 3'b000 and 3'b001 behave as hammer.
- R3: In walking-one mode, word k has only bit (k mod 16) set, so the pattern wraps from bit 15 back to bit 0.
- R4: In walking-zero mode, word k has only bit (k mod 16) clear.
- R5: In neighbor mode, word k is a background of all zeros for even k and all ones for odd k, with bit (k mod 16) inverted.
- R6: In address mode, the output word equals the low 16 bits of the current word address.
- R7: In PRBS mode, word 0 is the seed 16'hACE1. Each later word is the previous word shifted left by one, with bit 15 ^ bit 13 ^ bit 12 ^ bit 10 of the previous word entering at bit 0.
- R8: The read side regenerates the expected word from its own read count. A read-back of correctly stored words leaves the error flag low.
- R9: A read strobe whose data differs from the expected word sets the error flag on the following cycle. The flag then stays set through later correct reads until reset.
- R10: After reset the error flag is low, and both the write count and the read count start at word 0.
- R11: A write strobe and a read strobe in the same cycle each advance their own count. Neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; mode is captured while low |
| mode_i | input | 3 | Pattern select, captured during reset |
| addr_i | input | ADDR_W | Current word address |
| wr_stb_i | input | 1 | Write word taken; advances the write count |
| rd_stb_i | input | 1 | Read word valid; compare and advance the read count |
| rd_data_i | input | 16 | Word read back from memory |
| wr_data_o | output | 16 | Generated write word for the current write position |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
A write and a read can fall in the same cycle. In that cycle the write counter moves on to the next word while the read side compares and moves its own counter. The bench provokes this in PRBS mode. It first writes several words ahead, then raises both strobes together for a stretch of cycles. Each pair is judged by checking that the generated write word follows the pseudo-random sequence at the write count, and that the error flag stays low while every read returns the word stored at the read count.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    localparam int DW    = 16;
    localparam int POS_W = $clog2(DW);
    localparam logic [DW-1:0] PRBS_SEED = 16'hACE1;

    typedef enum logic [2:0] {
        PAT_ADDR   = 3'b010,
        PAT_HAMMER = 3'b011,
        PAT_NEIGH  = 3'b100,
        PAT_WALK1  = 3'b101,
        PAT_WALK0  = 3'b110,
        PAT_PRBS   = 3'b111
    } pat_e;

    typedef enum logic {
        CHK_CLEAN  = 1'b0,
        CHK_FAILED = 1'b1
    } chk_state_e;

    function automatic pat_e decode_mode(input logic [2:0] m);
        pat_e p;
        unique case (m)
            3'b010:  p = PAT_ADDR;
            3'b100:  p = PAT_NEIGH;
            3'b101:  p = PAT_WALK1;
            3'b110:  p = PAT_WALK0;
            3'b111:  p = PAT_PRBS;
            default: p = PAT_HAMMER;
        endcase
        return p;
    endfunction

    function automatic logic [DW-1:0] prbs_step(input logic [DW-1:0] s);
        return {s[DW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/memtest_patgen.sv
module memtest_patgen
    import memtest_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  pat_e          pat,
    input  logic          step,
    input  logic [DW-1:0] addr_lo,
    output logic [DW-1:0] word
);

    logic [POS_W-1:0] pos_q;
    logic [DW-1:0]    lfsr_q;
    logic [DW-1:0]    one_hot;
    logic [DW-1:0]    backdrop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            lfsr_q <= PRBS_SEED;
        end else if (step) begin
            pos_q  <= pos_q + 1'b1;
            lfsr_q <= prbs_step(lfsr_q);
        end
    end

    always_comb begin
        one_hot  = '0;
        one_hot[pos_q] = 1'b1;
        backdrop = {DW{pos_q[0]}};
    end

    always_comb begin
        unique case (pat)
            PAT_ADDR:   word = addr_lo;
            PAT_HAMMER: word = {DW{~pos_q[0]}};
            PAT_NEIGH:  word = backdrop ^ one_hot;
            PAT_WALK1:  word = one_hot;
            PAT_WALK0:  word = ~one_hot;
            PAT_PRBS:   word = lfsr_q;
            default:    word = {DW{~pos_q[0]}};
        endcase
    end

endmodule

// File: rtl/memtest_errfsm.sv
module memtest_errfsm
    import memtest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    output logic flag
);

    chk_state_e state_q;
    chk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_CLEAN:  if (miss) state_d = CHK_FAILED;
            CHK_FAILED: state_d = CHK_FAILED;
            default:    state_d = CHK_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CHK_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == CHK_FAILED);
    end

endmodule

// File: rtl/memtest_pattern_unit.sv
module memtest_pattern_unit
    import memtest_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_stb_i,
    input  logic              rd_stb_i,
    input  logic [15:0]       rd_data_i,
    output logic [15:0]       wr_data_o,
    output logic              err_o
);

    pat_e          pat_q;
    logic [DW-1:0] addr_lo;
    logic [DW-1:0] exp_word;
    logic          miss;

    always_ff @(posedge clk) begin
        if (!rst_n) pat_q <= decode_mode(mode_i);
    end

    assign addr_lo = DW'(addr_i);

    memtest_patgen u_wgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat     (pat_q),
        .step    (wr_stb_i),
        .addr_lo (addr_lo),
        .word    (wr_data_o)
    );

    memtest_patgen u_rgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat     (pat_q),
        .step    (rd_stb_i),
        .addr_lo (addr_lo),
        .word    (exp_word)
    );

    assign miss = rd_stb_i && (rd_data_i != exp_word);

    memtest_errfsm u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .miss  (miss),
        .flag  (err_o)
    );

endmodule

// File: rtl/memtest_pattern_unit_chk.sv
module memtest_pattern_unit_chk
    import memtest_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input pat_e        pat_q,
    input logic        wr_stb_i,
    input logic        rd_stb_i,
    input logic [15:0] wr_data_o,
    input logic        err_o
);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9
    err_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(rd_stb_i));

    // R2
    hammer_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == PAT_HAMMER && $past(rst_n) && $past(wr_stb_i))
            |-> wr_data_o == ~$past(wr_data_o));

    // R3
    walk1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == PAT_WALK1) |-> $countones(wr_data_o) == 1);

    // R4
    walk0_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == PAT_WALK0) |-> $countones(wr_data_o) == 15);

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pat_q));

endmodule

bind memtest_pattern_unit memtest_pattern_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_q     (pat_q),
    .wr_stb_i  (wr_stb_i),
    .rd_stb_i  (rd_stb_i),
    .wr_data_o (wr_data_o),
    .err_o     (err_o)
);

// File: tb/memtest_pattern_unit_bench.sv
module memtest_pattern_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_i = 3'b011;
    logic [AW-1:0] addr_i = '0;
    logic          wr_stb_i = 1'b0;
    logic          rd_stb_i = 1'b0;
    logic [15:0]   rd_data_i = '0;
    logic [15:0]   wr_data_o;
    logic          err_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    memtest_pattern_unit #(.ADDR_W(AW)) u_memtest_pattern_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .addr_i    (addr_i),
        .wr_stb_i  (wr_stb_i),
        .rd_stb_i  (rd_stb_i),
        .rd_data_i (rd_data_i),
        .wr_data_o (wr_data_o),
        .err_o     (err_o)
    );

    function automatic logic [15:0] prbs_at(input int k);
        logic [15:0] s = 16'hACE1;
        for (int i = 0; i < k; i++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return s;
    endfunction

    function automatic logic [15:0] expect_word(input logic [2:0] m, input int k,
                                                input logic [AW-1:0] a);
        logic [15:0] oh = 16'h1 << (k % 16);
        case (m)
            3'b010:  return a[15:0];
            3'b100:  return ((k % 2) ? 16'hFFFF : 16'h0000) ^ oh;
            3'b101:  return oh;
            3'b110:  return ~oh;
            3'b111:  return prbs_at(k);
            default: return (k % 2) ? 16'h0000 : 16'hFFFF;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; wr_stb_i = 0; rd_stb_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // writes n words starting at address base; checks each generated word
    task automatic write_run(input string req, input logic [2:0] m, input int n, input int base);
        for (int k = 0; k < n; k++) begin
            addr_i = AW'(base + k);
            #1;
            check(req, wr_data_o, expect_word(m, k, addr_i));
            mem[(base + k) % 64] = wr_data_o;
            wr_stb_i = 1'b1;
            @(negedge clk);
            wr_stb_i = 1'b0;
        end
    endtask

    task automatic read_run(input int n, input int base);
        for (int k = 0; k < n; k++) begin
            addr_i = AW'(base + k);
            rd_data_i = mem[(base + k) % 64];
            rd_stb_i = 1'b1;
            @(negedge clk);
            rd_stb_i = 1'b0;
        end
    endtask

    task automatic t_reset_state;
        do_reset(3'b011);
        #1;
        check("R10 err low", {15'd0, err_o}, 16'd0);
        check("R10 first word", wr_data_o, 16'hFFFF);
    endtask

    task automatic t_pattern(input string req, input logic [2:0] m, input int n, input int base);
        do_reset(m);
        write_run(req, m, n, base);
        read_run(n, base);
        check({"R8 readback ", req}, {15'd0, err_o}, 16'd0);
    endtask

    task automatic t_mode_ignored;
        do_reset(3'b101);
        write_run("R1 walk1", 3'b101, 2, 0);
        mode_i = 3'b011;
        @(negedge clk);
        for (int k = 2; k < 5; k++) begin
            #1;
            check("R1 mode change ignored", wr_data_o, expect_word(3'b101, k, addr_i));
            wr_stb_i = 1'b1;
            @(negedge clk);
            wr_stb_i = 1'b0;
        end
        do_reset(3'b011);
        #1;
        check("R1 mode after reset", wr_data_o, 16'hFFFF);
    endtask

    task automatic t_error_sticky;
        do_reset(3'b011);
        write_run("R2 hammer", 3'b011, 3, 0);
        addr_i = '0; rd_data_i = 16'hFFFE; rd_stb_i = 1'b1;
        #1;
        check("R9 no flag before edge", {15'd0, err_o}, 16'd0);
        @(negedge clk);
        rd_stb_i = 1'b0;
        check("R9 flag set", {15'd0, err_o}, 16'd1);
        read_run(2, 1);
        check("R9 flag sticky", {15'd0, err_o}, 16'd1);
        do_reset(3'b011);
        #1;
        check("R9 reset clears", {15'd0, err_o}, 16'd0);
    endtask

    task automatic t_overlap;
        do_reset(3'b111);
        write_run("R7 prbs lead", 3'b111, 3, 0);
        for (int k = 0; k < 8; k++) begin
            addr_i = AW'(k);
            rd_data_i = mem[k];
            #1;
            check("R11 write word during read", wr_data_o, prbs_at(k + 3));
            mem[k + 3] = wr_data_o;
            wr_stb_i = 1'b1; rd_stb_i = 1'b1;
            @(negedge clk);
            wr_stb_i = 1'b0; rd_stb_i = 1'b0;
        end
        check("R11 flag low after overlap", {15'd0, err_o}, 16'd0);
        read_run(3, 8);
        check("R8 flag low after tail", {15'd0, err_o}, 16'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_pattern("R2 hammer", 3'b011, 6, 0);
        t_pattern("R2 mode000", 3'b000, 4, 0);
        t_pattern("R2 mode001", 3'b001, 4, 0);
        t_pattern("R3 walk1", 3'b101, 20, 0);
        t_pattern("R4 walk0", 3'b110, 20, 0);
        t_pattern("R5 neighbor", 3'b100, 20, 0);
        t_pattern("R6 address", 3'b010, 8, 37);
        t_pattern("R7 prbs", 3'b111, 24, 0);
        t_mode_ignored();
        t_error_sticky();
        t_overlap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule